// File: doc/BRIEF.md
# Half-Warp Memory Coalescing Detector

This block takes one group of sixteen thread accesses at a time: one address per thread, a flag per thread that marks it active, and one access-size code for the whole group. It decides whether the group may be served by a single memory transaction. When it may, the block sends out one burst request that carries the group base address and a length of sixteen times the access size. When it may not, the block sends one request per active thread, in rising thread order.

A group may merge only if three conditions hold. Every active thread n must address base + size × n. The base must be a multiple of 16 × size. The size must be 4, 8 or 16 bytes. The base is derived from the lowest-numbered active thread. Inactive threads play no part in the check and get no request. Each outgoing request uses a valid/ready handshake. At the end of every group the block gives a one-cycle completion pulse that says whether the group was merged. A free-running counter holds the number of transactions issued since reset.

The size code is the base-2 logarithm of the access size in bytes, so code c means 2^c bytes. A new group is taken only while the block is idle.

Top module: `coal_unit`

## Requirements
- R1: After reset, grp_ready is 1, req_valid is 0, done_valid is 0 and txn_count is 0.
- R2: A group merges when all of the following hold: the size code is 2, 3 or 4 (4, 8 or 16 bytes); every active thread n holds base + (n << code); and base is a multiple of 16 << code. A merged group issues exactly one request, with req_burst=1, req_addr=base and req_len=16 << code (64, 128 or 256).
- R3: A group whose derived base is not a multiple of 16 << code is not merged, even if the addresses follow the stride pattern.
- R4: Any size code other than 2, 3 or 4 forces the non-merged path, even for a perfectly strided and aligned group.
- R5: The address of an inactive thread does not affect the merge decision and never appears on req_addr.
- R6: A non-merged group issues one request per active thread, in ascending thread index. Each request has req_addr equal to that thread's address, req_len=1 << code and req_burst=0.
- R7: While req_valid is 1 and req_ready is 0, req_addr, req_len and req_burst stay unchanged.
- R8: A group with no active thread issues no request. It still produces a completion pulse, with done_merged=0.
- R9: grp_ready is 0 from group acceptance until the completion pulse. done_valid lasts one cycle, in the cycle after the last request handshake, and done_merged reports the merge decision.
- R10: txn_count rises by exactly one on each request handshake and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A group is offered |
| grp_ready | output | 1 | Block is idle and takes the offered group |
| grp_addr | input | NTHR*AW | Thread addresses; thread n occupies bits n*AW +: AW |
| grp_active | input | NTHR | Bit n set means thread n is active |
| grp_size | input | SCW | Access size code c, meaning 2^c bytes |
| req_valid | output | 1 | Request is presented |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | AW | Request address |
| req_len | output | LW | Request length in bytes |
| req_burst | output | 1 | 1 for a merged burst, 0 for a single-thread request |
| done_valid | output | 1 | One-cycle completion pulse per group |
| done_merged | output | 1 | Merge decision of the completed group |
| txn_count | output | CW | Number of transactions issued since reset |

## Verification
The case that is hardest to reach from the ports is a group that meets every merge condition except one: an aligned stride pattern with a legal size in which a single active thread is off by one stride, the base is shifted by one size step, or the size code falls just outside the legal range. Random addresses almost never line up, so the stimulus first builds a correct aligned stride for the chosen size and then applies one perturbation at random. Sometimes the perturbation lands on an inactive thread, where it must not change the outcome. Directed groups add a lone active thread in the middle of the group, an empty group, and a perfect stride with a 1-byte size.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } coal_state_e;

    localparam int unsigned SZ_CODE_MIN = 2;
    localparam int unsigned SZ_CODE_MAX = 4;
    localparam int unsigned ALIGN_SHIFT = 4;

endpackage

// File: rtl/coal_pick.sv
module coal_pick #(
    parameter int unsigned NTHR = 16,
    localparam int unsigned IW  = $clog2(NTHR)
) (
    input  logic [NTHR-1:0] mask_i,
    output logic [IW-1:0]   idx_o,
    output logic            any_o
);

    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = NTHR - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/coal_check.sv
module coal_check
    import coal_pkg::*;
#(
    parameter int unsigned NTHR = 16,
    parameter int unsigned AW   = 32,
    parameter int unsigned SCW  = 3,
    localparam int unsigned IW  = $clog2(NTHR)
) (
    input  logic [NTHR*AW-1:0] addr_i,
    input  logic [NTHR-1:0]    act_i,
    input  logic [SCW-1:0]     code_i,
    output logic               ok_o,
    output logic [AW-1:0]      base_o
);

    logic [IW-1:0]   lead_idx;
    logic            lead_any;
    logic [AW-1:0]   lead_addr;
    logic [AW-1:0]   lead_off;
    logic [AW-1:0]   align_mask;
    logic [NTHR-1:0] hit;
    logic            size_ok;
    logic            aligned;

    coal_pick #(.NTHR(NTHR)) u_lead (
        .mask_i (act_i),
        .idx_o  (lead_idx),
        .any_o  (lead_any)
    );

    assign lead_addr  = addr_i[lead_idx*AW +: AW];
    assign lead_off   = AW'(lead_idx) << code_i;
    assign base_o     = lead_addr - lead_off;
    assign align_mask = (AW'(1) << (AW'(code_i) + AW'(ALIGN_SHIFT))) - AW'(1);
    assign aligned    = (base_o & align_mask) == '0;
    assign size_ok    = (code_i >= SCW'(SZ_CODE_MIN)) && (code_i <= SCW'(SZ_CODE_MAX));

    for (genvar n = 0; n < NTHR; n++) begin : g_thr
        logic [AW-1:0] want;
        assign want   = base_o + (AW'(n) << code_i);
        assign hit[n] = !act_i[n] || (addr_i[n*AW +: AW] == want);
    end

    assign ok_o = lead_any && size_ok && aligned && (&hit);

endmodule

// File: rtl/coal_count.sv
module coal_count #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/coal_unit.sv
module coal_unit
    import coal_pkg::*;
#(
    parameter int unsigned NTHR = 16,
    parameter int unsigned AW   = 32,
    parameter int unsigned SCW  = 3,
    parameter int unsigned CW   = 16,
    localparam int unsigned LW  = SCW + ALIGN_SHIFT + 2 + 1,
    localparam int unsigned IW  = $clog2(NTHR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_valid,
    output logic               grp_ready,
    input  logic [NTHR*AW-1:0] grp_addr,
    input  logic [NTHR-1:0]    grp_active,
    input  logic [SCW-1:0]     grp_size,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [AW-1:0]      req_addr,
    output logic [LW-1:0]      req_len,
    output logic               req_burst,
    output logic               done_valid,
    output logic               done_merged,
    output logic [CW-1:0]      txn_count
);

    typedef struct packed {
        coal_state_e        st;
        logic [NTHR*AW-1:0] addr;
        logic [NTHR-1:0]    pend;
        logic [SCW-1:0]     code;
        logic               merged;
        logic [AW-1:0]      base;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic          chk_ok;
    logic [AW-1:0] chk_base;
    logic [IW-1:0] nxt_idx;
    logic          nxt_any;
    logic          hs;

    coal_check #(.NTHR(NTHR), .AW(AW), .SCW(SCW)) u_check (
        .addr_i (grp_addr),
        .act_i  (grp_active),
        .code_i (grp_size),
        .ok_o   (chk_ok),
        .base_o (chk_base)
    );

    coal_pick #(.NTHR(NTHR)) u_next (
        .mask_i (ctl_q.pend),
        .idx_o  (nxt_idx),
        .any_o  (nxt_any)
    );

    coal_count #(.CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (hs),
        .count_o (txn_count)
    );

    assign grp_ready = (ctl_q.st == ST_IDLE);
    assign req_valid = (ctl_q.st == ST_ISSUE) && (ctl_q.merged || nxt_any);
    assign hs        = req_valid && req_ready;

    always_comb begin
        req_burst = ctl_q.merged;
        if (ctl_q.merged) begin
            req_addr = ctl_q.base;
            req_len  = LW'(1) << (LW'(ctl_q.code) + LW'(ALIGN_SHIFT));
        end else begin
            req_addr = ctl_q.addr[nxt_idx*AW +: AW];
            req_len  = LW'(1) << ctl_q.code;
        end
    end

    assign done_valid  = (ctl_q.st == ST_DONE);
    assign done_merged = done_valid && ctl_q.merged;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (grp_valid) begin
                    ctl_d.addr   = grp_addr;
                    ctl_d.pend   = grp_active;
                    ctl_d.code   = grp_size;
                    ctl_d.merged = chk_ok;
                    ctl_d.base   = chk_base;
                    ctl_d.st     = (|grp_active) ? ST_ISSUE : ST_DONE;
                end
            end
            ST_ISSUE: begin
                if (hs) begin
                    if (ctl_q.merged) begin
                        ctl_d.pend = '0;
                    end else begin
                        ctl_d.pend[nxt_idx] = 1'b0;
                    end
                    if (ctl_d.pend == '0) begin
                        ctl_d.st = ST_DONE;
                    end
                end else if (!ctl_q.merged && !nxt_any) begin
                    ctl_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.addr   <= '0;
            ctl_q.pend   <= '0;
            ctl_q.code   <= '0;
            ctl_q.merged <= 1'b0;
            ctl_q.base   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/coal_unit_chk.sv
module coal_unit_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 10,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grp_ready,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [LW-1:0] req_len,
    input logic          req_burst,
    input logic          done_valid,
    input logic          done_merged,
    input logic [CW-1:0] txn_count
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_burst))); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (txn_count == CW'($past(txn_count) + CW'(1)))); // R10

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(txn_count)); // R10

    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || done_valid) |-> !grp_ready); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R9

    AST_MERGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_merged |-> done_valid); // R9

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst) |-> ($countones(req_len) == 1 && req_len >= LW'(64) && req_len <= LW'(256))); // R2

    AST_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(req_len) == 1)); // R6

endmodule

bind coal_unit coal_unit_chk #(.AW(AW), .LW(LW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_ready   (grp_ready),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_burst   (req_burst),
    .done_valid  (done_valid),
    .done_merged (done_merged),
    .txn_count   (txn_count)
);

// File: tb/sim_coal_unit.sv
`timescale 1ns/1ps
module sim_coal_unit;

    localparam int NT = 16;
    localparam int AW = 32;
    localparam int SCW = 3;
    localparam int CW = 16;
    localparam int LW = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              grp_valid = 1'b0;
    logic              grp_ready;
    logic [NT*AW-1:0]  grp_addr = '0;
    logic [NT-1:0]     grp_active = '0;
    logic [SCW-1:0]    grp_size = '0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [AW-1:0]     req_addr;
    logic [LW-1:0]     req_len;
    logic              req_burst;
    logic              done_valid;
    logic              done_merged;
    logic [CW-1:0]     txn_count;

    always #4 clk = ~clk;

    coal_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_addr(grp_addr), .grp_active(grp_active), .grp_size(grp_size),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_burst(req_burst),
        .done_valid(done_valid), .done_merged(done_merged),
        .txn_count(txn_count)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    int ready_pct = 70;

    logic [AW-1:0] ta [NT];
    logic [AW-1:0] exp_addr [NT];
    logic [LW-1:0] exp_len [NT];
    logic          exp_burst [NT];
    int            exp_n;
    logic          exp_merged;
    string         exp_tag;
    int            got;
    int            total;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // expected outcome of a group from the requirements
    task automatic predict(input logic [NT-1:0] act, input logic [SCW-1:0] code);
        int lead;
        logic [AW-1:0] base;
        bit ok;
        lead = -1;
        for (int n = NT - 1; n >= 0; n--) if (act[n]) lead = n;
        ok = (lead >= 0) && (code >= 2) && (code <= 4);
        base = '0;
        if (lead >= 0) base = ta[lead] - AW'(lead * (1 << code));
        if (ok && (base % (32'd16 << code)) != 0) ok = 0;
        for (int n = 0; n < NT; n++)
            if (ok && act[n] && ta[n] != base + AW'(n * (1 << code))) ok = 0;
        exp_merged = ok;
        exp_n = 0;
        if (ok) begin
            exp_addr[0] = base; exp_len[0] = LW'(16 << code); exp_burst[0] = 1'b1;
            exp_n = 1;
            exp_tag = "R2";
        end else begin
            for (int n = 0; n < NT; n++) if (act[n]) begin
                exp_addr[exp_n] = ta[n]; exp_len[exp_n] = LW'(1 << code);
                exp_burst[exp_n] = 1'b0; exp_n++;
            end
            if (lead < 0) exp_tag = "R8";
            else if (code < 2 || code > 4) exp_tag = "R4";
            else exp_tag = "R3";
        end
    endtask

    task automatic run_group(input logic [NT-1:0] act, input logic [SCW-1:0] code,
                             input string tag_over);
        predict(act, code);
        if (tag_over != "") exp_tag = tag_over;
        got = 0;
        @(negedge clk);
        for (int n = 0; n < NT; n++) grp_addr[n*AW +: AW] = ta[n];
        grp_active = act;
        grp_size = code;
        grp_valid = 1'b1;
        while (!grp_ready) @(negedge clk);
        @(negedge clk);
        grp_valid = 1'b0;
        grp_addr = {NT{32'hDEAD_BEEF}};
        while (!done_valid) @(negedge clk);
        check(done_merged == exp_merged, exp_tag, "merge flag", done_merged, exp_merged);
        check(got == exp_n, exp_n == 0 ? "R8" : "R6", "request count", got, exp_n);
        check(!grp_ready, "R9", "ready during done", grp_ready, 0);
        check(txn_count == CW'(total), "R10", "txn_count", txn_count, total);
        @(negedge clk);
        check(!done_valid, "R9", "done pulse width", done_valid, 0);
    endtask

    // request monitor
    logic [AW-1:0] held_addr;
    logic [LW-1:0] held_len;
    bit            stalled = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                if (stalled)
                    check(req_addr == held_addr && req_len == held_len, "R7",
                          "held request", req_addr, held_addr);
                stalled = !req_ready;
                held_addr = req_addr;
                held_len = req_len;
                if (req_ready) begin
                    if (got < exp_n) begin
                        check(req_addr == exp_addr[got], exp_burst[got] ? "R2" : "R6",
                              "req_addr", req_addr, exp_addr[got]);
                        check(req_len == exp_len[got], exp_burst[got] ? "R2" : "R6",
                              "req_len", req_len, exp_len[got]);
                        check(req_burst == exp_burst[got], exp_burst[got] ? "R2" : "R6",
                              "req_burst", req_burst, exp_burst[got]);
                    end else begin
                        check(1'b0, "R6", "extra request", got, exp_n);
                    end
                    got++;
                    total++;
                end
            end else begin
                stalled = 1'b0;
            end
        end
    end

    // ready driver, off the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1 req_ready = ($urandom % 100) < ready_pct;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic fill_stride(input logic [AW-1:0] base, input logic [SCW-1:0] code);
        for (int n = 0; n < NT; n++) ta[n] = base + AW'(n * (1 << code));
    endtask

    initial begin
        logic [SCW-1:0] c;
        logic [AW-1:0]  b;
        logic [NT-1:0]  a;
        int k;
        void'($urandom(32'd2024));
        total = 0;
        exp_n = 0;
        repeat (3) @(negedge clk);
        check(grp_ready == 1'b1, "R1", "grp_ready at reset", grp_ready, 1);
        check(req_valid == 1'b0, "R1", "req_valid at reset", req_valid, 0);
        check(done_valid == 1'b0, "R1", "done_valid at reset", done_valid, 0);
        check(txn_count == '0, "R1", "txn_count at reset", txn_count, 0);
        rst_n = 1'b1;

        // R2: full aligned stride, each legal size
        for (int s = 2; s <= 4; s++) begin
            fill_stride(32'h0001_0000, SCW'(s));
            run_group(16'hFFFF, SCW'(s), "R2");
        end
        // R3: stride pattern, base one size step off alignment
        fill_stride(32'h0001_0010, 3'd4);
        run_group(16'hFFFF, 3'd4, "R3");
        // R4: perfect stride, 1-byte and 32-byte codes
        fill_stride(32'h0002_0000, 3'd0);
        run_group(16'hFFFF, 3'd0, "R4");
        fill_stride(32'h0002_0000, 3'd5);
        run_group(16'hFFFF, 3'd5, "R4");
        // R5: inactive thread with a stray address still merges
        fill_stride(32'h0003_0000, 3'd2);
        ta[7] = 32'h1234_5677;
        run_group(16'hFF7F, 3'd2, "R5");
        // R5: lone active thread in the middle merges as a burst
        fill_stride(32'h0004_0000, 3'd3);
        for (int n = 0; n < NT; n++) if (n != 5) ta[n] = $urandom;
        run_group(16'h0020, 3'd3, "R5");
        // R6: one active thread off by a stride breaks the merge
        fill_stride(32'h0005_0000, 3'd2);
        ta[9] = ta[9] + 32'd4;
        run_group(16'hFFFF, 3'd2, "R6");
        // R8: empty group
        run_group(16'h0000, 3'd2, "R8");
        // R7: slow memory side
        ready_pct = 20;
        for (int n = 0; n < NT; n++) ta[n] = $urandom;
        run_group(16'hA5C3, 3'd1, "R7");
        ready_pct = 70;

        // constrained random
        for (int g = 0; g < 300; g++) begin
            if (($urandom % 10) < 7) c = SCW'(2 + ($urandom % 3));
            else c = SCW'($urandom % 8);
            b = $urandom;
            if (($urandom % 4) != 0) b = b & ~((32'd16 << c) - 1);
            fill_stride(b, c);
            case ($urandom % 4)
                0: a = 16'hFFFF;
                1: a = 16'(1 << ($urandom % 16));
                default: a = 16'($urandom);
            endcase
            if (($urandom % 4) == 0) begin
                k = $urandom % NT;
                ta[k] = ta[k] + AW'(1 << c);
            end
            if (($urandom % 8) == 0) ta[$urandom % NT] = $urandom;
            run_group(a, c, "");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule